// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block turns a pixel clock into the horizontal and vertical sync and blanking waveforms of a raster display. A line counter runs over the clocks of each line. A vertical counter runs over the lines of a frame, or over the half-lines of a field when interlace is on. Every edge is placed by a 12-bit end count that arrives on parallel inputs. All counts are 1-based. A pulse that ends at count N is active up to count N-1 and goes inactive at N.

A control word sets four things: the scan mode, the polarity of each of the four sync and blank pins, a clock-run enable, and an output-select code. For each pin pair, the select code chooses between two sources. The blank and sync pins carry either the vertical component or the composite of horizontal and vertical. The two auxiliary pins carry either the horizontal blank and sync or a pair of gating windows. An odd/even flag marks the field. A synchronous restart input puts the raster back at the first count of the odd field. This lets software start a new timing set cleanly or line the raster up with an outside event.

Top module: `raster_sync_gen`

## Requirements
- R1: The line counter runs 1, 2, …, `h_total_i` and then returns to 1, so one line lasts `h_total_i` clocks. The counter value is never 0.
- R2: Horizontal blank is active for line counts 1 to `h_blank_end_i`-1. Horizontal sync is active for counts `h_fp_end_i` to `h_sync_end_i`-1. The horizontal gate is active for counts in the window [`hgate_start_i`, `hgate_end_i`). The gate window wraps through the line end when its start is greater than its stop.
- R3: When `ctrl_i[4:3]` is 00 the mode is interlaced, and any other value is progressive. The vertical counter steps once per line in progressive mode. In interlaced mode it steps twice per line, at line counts `h_total_i`/2 and `h_total_i`. It runs 1 to `v_total_i` and then returns to 1. Vertical blank is active while the counter is below `v_blank_end_i`. Vertical sync is active while the counter is in [`v_fp_end_i`, `v_sync_end_i`). The vertical gate uses the window [`vgate_start_i`, `vgate_end_i`) and wraps the same way as the horizontal gate.
- R4: Vertical blank and the vertical gate re-evaluate only at the first clock of each line. In interlaced mode they also re-evaluate at the first clock of each half-line, which is line count `h_total_i`/2+1. Vertical sync re-evaluates only at line count `h_fp_end_i`, or at that count plus `h_total_i`/2 in interlaced mode. Between these points each one keeps its last value.
- R5: `odd_field_o` is 1 in the odd field and 0 in the even field. In interlaced mode it toggles each time the vertical counter wraps from `v_total_i` to 1. In progressive mode it stays 1.
- R6: The composite blank is active when either horizontal or vertical blank is active. The composite sync is active when either horizontal or vertical sync is active.
- R7: `ctrl_i[0]` selects vertical blank (1) or composite blank (0) on `blank_o`. The same bit selects horizontal blank (1) or the horizontal gate (0) on `haux_o`. `ctrl_i[1]` selects vertical sync (1) or composite sync (0) on `sync_o`. The same bit selects horizontal sync (1) or the vertical gate (0) on `vaux_o`. `ctrl_i[2]` has no effect.
- R8: Control bits 5, 6, 7 and 8 set the polarity of `blank_o`, `sync_o`, `haux_o` and `vaux_o` in that order. A 1 in one of these bits makes its output active-high, and a 0 makes it active-low.
- R9: While `ctrl_i[10]` is 0, the counters, the field flag and all outputs hold their values.
- R10: `restart_i` is synchronous and acts even when the clock-run bit is clear. It sets both counters to 1 and selects the odd field. The outputs are registered, so each output shows the counter state of the previous clock. The first enabled edge after a restart presents line count 1 and vertical count 1.
- R11: Timing values may be lowered while a counter is already past the new total. In that case the counter keeps counting up to 4095 and then returns to 1.
- R12: Reset is synchronous and active-high. It leaves every sync and blank output in its inactive state for the current polarity, with `odd_field_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Synchronous raster restart to the start of the odd field |
| ctrl_i | input | 12 | Control word: select [2:0], mode [4:3], polarity [8:5], run [10] |
| h_fp_end_i | input | 12 | Line count where the front porch ends and horizontal sync begins |
| h_sync_end_i | input | 12 | Line count where horizontal sync ends |
| h_blank_end_i | input | 12 | Line count where horizontal blank ends |
| h_total_i | input | 12 | Clocks per line (even) |
| v_fp_end_i | input | 12 | Vertical count where vertical sync begins |
| v_sync_end_i | input | 12 | Vertical count where vertical sync ends |
| v_blank_end_i | input | 12 | Vertical count where vertical blank ends |
| v_total_i | input | 12 | Lines per frame, which is half-lines per field in interlaced mode |
| hgate_start_i | input | 12 | Horizontal gate window start |
| hgate_end_i | input | 12 | Horizontal gate window stop |
| vgate_start_i | input | 12 | Vertical gate window start |
| vgate_end_i | input | 12 | Vertical gate window stop |
| blank_o | output | 1 | Composite or vertical blank |
| sync_o | output | 1 | Composite or vertical sync |
| haux_o | output | 1 | Horizontal blank or horizontal gate |
| vaux_o | output | 1 | Horizontal sync or vertical gate |
| odd_field_o | output | 1 | Field flag, 1 in the odd field |

## Verification
Two pairs of events can fall on the same edge. The first pair is a restart and a cleared clock-run bit. The bench drives a restart while the run bit is 0, and then expects the first enabled output to match count 1 of the odd field. The second pair is a vertical step and a field wrap, which coincide with the latched vertical sync update at the half-line boundary. The bench checks these by sweeping every select code, both scan modes and several polarity sets over more than one full frame. It compares each cycle against waveforms computed in the bench from the clock index alone, by integer division into lines and half-lines.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    localparam int CNT_W  = 12;
    localparam int CTRL_W = 12;

    // control word field positions
    localparam int SEL0_BIT  = 0;
    localparam int SEL1_BIT  = 1;
    localparam int MODE_LO   = 3;
    localparam int MODE_HI   = 4;
    localparam int POL_LO    = 5;
    localparam int POL_HI    = 8;
    localparam int RUN_BIT   = 10;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_ONE = cnt_t'(1);
    localparam cnt_t CNT_MAX = '1;

    typedef struct packed {
        cnt_t fp_end;
        cnt_t sync_end;
        cnt_t blank_end;
        cnt_t total;
    } axis_cfg_t;

    typedef struct packed {
        cnt_t start;
        cnt_t stop;
    } window_t;

    typedef struct packed {
        logic blank;
        logic sync;
        logic gate;
    } axis_raw_t;

    typedef struct packed {
        logic vaux;
        logic haux;
        logic sync;
        logic blank;
    } pins_t;

    function automatic logic in_window(input cnt_t x, input window_t w);
        if (w.start <= w.stop) return (x >= w.start) && (x < w.stop);
        else                   return (x >= w.start) || (x < w.stop);
    endfunction

endpackage

// File: rtl/rsg_hcount.sv
module rsg_hcount
    import rsg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      run,
    input  logic      ilace,
    input  axis_cfg_t cfg,
    input  window_t   gate,
    output cnt_t      hc,
    output axis_raw_t raw,
    output logic      vstep,
    output logic      vblank_pt,
    output logic      vsync_pt
);

    cnt_t half;
    cnt_t hc_next;
    logic line_end;

    always_comb begin
        half      = cfg.total >> 1;
        line_end  = (hc == cfg.total) || (hc == CNT_MAX);
        hc_next   = line_end ? CNT_ONE : hc + CNT_ONE;
        vstep     = line_end || (ilace && (hc == half));
        vblank_pt = (hc == CNT_ONE) || (ilace && (hc == half + CNT_ONE));
        vsync_pt  = (hc == cfg.fp_end) || (ilace && (hc == cfg.fp_end + half));
        raw.blank = hc < cfg.blank_end;
        raw.sync  = (hc >= cfg.fp_end) && (hc < cfg.sync_end);
        raw.gate  = in_window(hc, gate);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) hc <= CNT_ONE;
        else if (run)       hc <= hc_next;
    end

    // R1
    hc_nonzero_chk: assert property (@(posedge clk) disable iff (rst) hc != '0);
    // R1
    line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && hc == cfg.total) |=> hc == CNT_ONE);
    // R9
    hc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(hc));
    // R10
    hc_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> hc == CNT_ONE);
    // R11
    hc_rollover_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && hc == CNT_MAX) |=> hc == CNT_ONE);

endmodule

// File: rtl/rsg_vcount.sv
module rsg_vcount
    import rsg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      run,
    input  logic      ilace,
    input  axis_cfg_t cfg,
    input  window_t   gate,
    input  logic      vstep,
    input  logic      vblank_pt,
    input  logic      vsync_pt,
    output cnt_t      vc,
    output logic      odd,
    output axis_raw_t raw
);

    cnt_t      vc_next;
    logic      wrap;
    axis_raw_t held;

    always_comb begin
        wrap      = (vc == cfg.total) || (vc == CNT_MAX);
        vc_next   = wrap ? CNT_ONE : vc + CNT_ONE;
        raw.blank = vblank_pt ? (vc < cfg.blank_end) : held.blank;
        raw.gate  = vblank_pt ? in_window(vc, gate) : held.gate;
        raw.sync  = vsync_pt ? ((vc >= cfg.fp_end) && (vc < cfg.sync_end)) : held.sync;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            vc   <= CNT_ONE;
            odd  <= 1'b1;
            held <= '0;
        end else if (run) begin
            held <= raw;
            if (vstep) begin
                vc <= vc_next;
                if (ilace && (vc == cfg.total)) odd <= ~odd;
            end
        end
    end

    // R5
    field_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && vstep && ilace && vc == cfg.total) |=> (odd != $past(odd)));
    // R3
    vc_step_only_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && !vstep) |=> $stable(vc));
    // R10
    vc_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (vc == CNT_ONE) && odd);

endmodule

// File: rtl/rsg_outmux.sv
module rsg_outmux
    import rsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       ilace,
    input  pins_t      pol,
    input  axis_raw_t  hraw,
    input  axis_raw_t  vraw,
    input  logic       odd,
    output pins_t      pins,
    output logic       odd_o
);

    pins_t act_d;
    pins_t act_q;

    always_comb begin
        act_d.blank = sel[0] ? vraw.blank : (hraw.blank | vraw.blank);
        act_d.haux  = sel[0] ? hraw.blank : hraw.gate;
        act_d.sync  = sel[1] ? vraw.sync  : (hraw.sync | vraw.sync);
        act_d.vaux  = sel[1] ? hraw.sync  : vraw.gate;
        pins        = act_q ^ ~pol;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            odd_o <= 1'b1;
        end else if (run) begin
            act_q <= act_d;
            odd_o <= ilace ? odd : 1'b1;
        end
    end

    // R5
    prog_odd_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !ilace) |=> odd_o);
    // R6
    comp_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !sel[0] && hraw.blank) |=> act_q.blank);
    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(act_q) && $stable(odd_o)));

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import rsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [CNT_W-1:0]  h_fp_end_i,
    input  logic [CNT_W-1:0]  h_sync_end_i,
    input  logic [CNT_W-1:0]  h_blank_end_i,
    input  logic [CNT_W-1:0]  h_total_i,
    input  logic [CNT_W-1:0]  v_fp_end_i,
    input  logic [CNT_W-1:0]  v_sync_end_i,
    input  logic [CNT_W-1:0]  v_blank_end_i,
    input  logic [CNT_W-1:0]  v_total_i,
    input  logic [CNT_W-1:0]  hgate_start_i,
    input  logic [CNT_W-1:0]  hgate_end_i,
    input  logic [CNT_W-1:0]  vgate_start_i,
    input  logic [CNT_W-1:0]  vgate_end_i,
    output logic              blank_o,
    output logic              sync_o,
    output logic              haux_o,
    output logic              vaux_o,
    output logic              odd_field_o
);

    axis_cfg_t hcfg, vcfg;
    window_t   hwin, vwin;
    axis_raw_t hraw, vraw;
    pins_t     pol, pins;
    cnt_t      hc, vc;
    logic      run, ilace, vstep, vblank_pt, vsync_pt, odd;
    logic      ctrl_unused;

    assign hcfg  = '{fp_end: h_fp_end_i, sync_end: h_sync_end_i,
                     blank_end: h_blank_end_i, total: h_total_i};
    assign vcfg  = '{fp_end: v_fp_end_i, sync_end: v_sync_end_i,
                     blank_end: v_blank_end_i, total: v_total_i};
    assign hwin  = '{start: hgate_start_i, stop: hgate_end_i};
    assign vwin  = '{start: vgate_start_i, stop: vgate_end_i};
    assign run   = ctrl_i[RUN_BIT];
    assign ilace = (ctrl_i[MODE_HI:MODE_LO] == 2'b00);
    assign pol   = ctrl_i[POL_HI:POL_LO];
    assign ctrl_unused = ^{ctrl_i[CTRL_W-1], ctrl_i[RUN_BIT-1], ctrl_i[SEL1_BIT+1]};

    rsg_hcount u_h (
        .clk(clk), .rst(rst), .restart(restart_i), .run(run), .ilace(ilace),
        .cfg(hcfg), .gate(hwin), .hc(hc), .raw(hraw),
        .vstep(vstep), .vblank_pt(vblank_pt), .vsync_pt(vsync_pt)
    );

    rsg_vcount u_v (
        .clk(clk), .rst(rst), .restart(restart_i), .run(run), .ilace(ilace),
        .cfg(vcfg), .gate(vwin), .vstep(vstep), .vblank_pt(vblank_pt),
        .vsync_pt(vsync_pt), .vc(vc), .odd(odd), .raw(vraw)
    );

    rsg_outmux u_o (
        .clk(clk), .rst(rst), .run(run),
        .sel({ctrl_i[SEL1_BIT], ctrl_i[SEL0_BIT]}), .ilace(ilace), .pol(pol),
        .hraw(hraw), .vraw(vraw), .odd(odd), .pins(pins), .odd_o(odd_field_o)
    );

    assign blank_o = pins.blank;
    assign sync_o  = pins.sync;
    assign haux_o  = pins.haux;
    assign vaux_o  = pins.vaux;

    // R12
    reset_odd_chk: assert property (@(posedge clk) rst |=> odd_field_o);
    // R10
    restart_pair_chk: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (hc == CNT_ONE) && (vc == CNT_ONE));

endmodule

// File: tb/tb_raster_sync_gen.sv
`timescale 1ns/1ps
module tb_raster_sync_gen;

    localparam int H   = 16;
    localparam int HFP = 3;
    localparam int HSE = 6;
    localparam int HBE = 9;
    localparam int HGS = 12;
    localparam int HGE = 4;
    localparam int V   = 9;
    localparam int VFP = 2;
    localparam int VSE = 4;
    localparam int VBE = 5;
    localparam int VGS = 3;
    localparam int VGE = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        restart = 1'b0;
    logic [11:0] ctrl = '0;
    logic [11:0] htot = 12'(H);
    logic        blank_o, sync_o, haux_o, vaux_o, odd_field_o;

    int tests = 0;
    int fails = 0;
    int kcap  = -1;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    raster_sync_gen dut (
        .clk(clk), .rst(rst), .restart_i(restart), .ctrl_i(ctrl),
        .h_fp_end_i(12'(HFP)), .h_sync_end_i(12'(HSE)), .h_blank_end_i(12'(HBE)),
        .h_total_i(htot),
        .v_fp_end_i(12'(VFP)), .v_sync_end_i(12'(VSE)), .v_blank_end_i(12'(VBE)),
        .v_total_i(12'(V)),
        .hgate_start_i(12'(HGS)), .hgate_end_i(12'(HGE)),
        .vgate_start_i(12'(VGS)), .vgate_end_i(12'(VGE)),
        .blank_o(blank_o), .sync_o(sync_o), .haux_o(haux_o), .vaux_o(vaux_o),
        .odd_field_o(odd_field_o)
    );

    function automatic logic win(int x, int s, int e);
        return (s <= e) ? (x >= s && x < e) : (x >= s || x < e);
    endfunction

    function automatic logic [11:0] mk(logic [2:0] sel, logic [1:0] mode,
                                       logic [3:0] pol, logic runb);
        logic [11:0] c = '0;
        c[2:0] = sel; c[4:3] = mode; c[8:5] = pol; c[10] = runb;
        return c;
    endfunction

    // expected {odd, vaux, haux, sync, blank} for clock index k since restart
    function automatic logic [4:0] expv(int k, logic [11:0] c);
        logic il = (c[4:3] == 2'b00);
        int   u = il ? H/2 : H;
        int   hc = k % H + 1;
        int   idx = k / u;
        int   q = k % u;
        int   vc = idx % V + 1;
        int   sidx = (q + 1 >= HFP) ? idx : idx - 1;
        int   vcs;
        logic hb, hs, hg, vb, vs, vg, odd, a, b, cc, d;
        hb = hc < HBE;
        hs = (hc >= HFP) && (hc < HSE);
        hg = win(hc, HGS, HGE);
        vb = vc < VBE;
        vg = win(vc, VGS, VGE);
        if (sidx < 0) vs = 1'b0;
        else begin
            vcs = sidx % V + 1;
            vs  = (vcs >= VFP) && (vcs < VSE);
        end
        odd = il ? ((idx / V) % 2 == 0) : 1'b1;
        a  = c[0] ? vb : (hb | vb);
        cc = c[0] ? hb : hg;
        b  = c[1] ? vs : (hs | vs);
        d  = c[1] ? hs : vg;
        return {odd, d ^ ~c[8], cc ^ ~c[7], b ^ ~c[6], a ^ ~c[5]};
    endfunction

    task automatic check(string req, logic [4:0] got, logic [4:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s at k=%0d got=%b exp=%b", req, kcap, got, exp);
        end
    endtask

    function automatic logic [4:0] pins();
        return {odd_field_o, vaux_o, haux_o, sync_o, blank_o};
    endfunction

    task automatic step(string req);
        @(posedge clk);
        if (ctrl[10]) kcap++;
        @(negedge clk);
        if (kcap >= 0) check(req, pins(), expv(kcap, ctrl));
    endtask

    task automatic do_restart();
        restart = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
        kcap = -1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 got=hang exp=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R12: reset state, active-low polarity
        repeat (3) @(negedge clk);
        check("R12 reset inactive low-pol", pins(), 5'b11111);
        // R8 R12: polarity flips the idle level during reset
        ctrl = mk(3'b000, 2'b00, 4'b1111, 1'b0);
        @(negedge clk);
        check("R8 R12 reset inactive high-pol", pins(), 5'b10000);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6 R7 R8 sweep over select, mode and polarity
        for (int i = 0; i < 16; i++) begin
            ctrl = mk(3'(i), (i >= 8) ? ((i % 2 == 1) ? 2'b11 : 2'b01) : 2'b00,
                      4'(i * 5 + 3), 1'b1);
            do_restart();
            for (int n = 0; n < 300; n++) step("R1 R2 R3 R4 R5 R6 R7 R8 sweep");
        end

        // R9: clock-run bit cleared holds everything
        ctrl = mk(3'b000, 2'b00, 4'b0101, 1'b1);
        do_restart();
        for (int n = 0; n < 77; n++) step("R9 pre-hold");
        ctrl[10] = 1'b0;
        for (int n = 0; n < 20; n++) step("R9 hold");
        ctrl[10] = 1'b1;
        for (int n = 0; n < 100; n++) step("R9 resume");

        // R10: restart while clock-run is clear still resets the raster
        for (int n = 0; n < 33; n++) step("R10 pre");
        ctrl[10] = 1'b0;
        @(negedge clk);
        do_restart();
        for (int n = 0; n < 5; n++) step("R10 disabled");
        ctrl[10] = 1'b1;
        for (int n = 0; n < 160; n++) step("R10 after restart");

        // R11: lowering the total below the current count rolls over at 4095
        ctrl = mk(3'b011, 2'b01, 4'b1111, 1'b1);
        do_restart();
        for (int n = 0; n < 11; n++) step("R11 pre");
        htot = 12'd8;
        begin
            int m = 0;
            bit seen = 1'b0;
            while (!seen && m < 5000) begin
                @(posedge clk);
                @(negedge clk);
                m++;
                if (haux_o) seen = 1'b1;
            end
            check("R11 rollover delay", 5'(m == 4085), 5'd1);
            if (m != 4085) $display("FAIL R11 got=%0d exp=4085", m);
        end
        htot = 12'(H);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule